// File: doc/BRIEF.md
# Glitch-Suppressing Split Adder/Subtractor

This block adds or subtracts two 16-bit operands while keeping the upper half of the carry chain quiet whenever it has no real work to do. The datapath is cut into a low byte and a high byte. A detector inspects the two high operand bytes, taking the subtrahend after its conditional inversion. When each of those bytes is only a sign extension (all zeros or all ones), the operands of the high-byte adder are ANDed down to zero, so that adder does not toggle. The upper result byte is then rebuilt by a small mux from the two sign bytes and the low-byte carry out.

Subtraction is formed as A + ~B + 1. The result is bit-exact against plain modular arithmetic for every operand pair. An optional input register stage sits ahead of the arithmetic, and the outputs are registered. A flag marks each result whose high adder was gated, and a wrapping counter totals the gated operations.

Top module: `glitch_split_addsub`

## Requirements
- R1: While reset is high and in the cycle after it, out_valid, result, gated and gated_count are all zero.
- R2: When the operation needs the high adder, its operand bytes pass through unchanged. When it does not, both operand bytes are forced to zero.
- R3: For each accepted operation, result equals (op_a + op_b) mod 2^16 when sub is 0, and (op_a - op_b) mod 2^16 when sub is 1.
- R4: gated is 1 exactly when op_a[15:8] is 0x00 or 0xFF and the effective high subtrahend byte is also 0x00 or 0xFF. The effective byte is op_b[15:8] when adding and ~op_b[15:8] when subtracting.
- R5: A result and its out_valid pulse appear two clock edges after the edge that samples in_valid high (default input register on). out_valid is never high without such a sample.
- R6: gated_count increases by exactly one, modulo 2^16, with every valid result whose gated flag is 1, and holds its value otherwise.
- R7: In cycles where no result is produced, out_valid is low and result and gated keep their last values.
- R8: Carries that cross the byte boundary in the gated mode are exact. Examples: 0x00FF+0x0001=0x0100, 0xFFFF+0xFFFF=0xFFFE, 0x0000-0x0001=0xFFFF, 0xFF80+0x0080=0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands present this cycle |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| sub | input | 1 | 1 selects op_a - op_b, 0 selects op_a + op_b |
| out_valid | output | 1 | Result present this cycle |
| result | output | 16 | Sum or difference modulo 2^16 |
| gated | output | 1 | High adder was gated for this result |
| gated_count | output | 16 | Running count of gated results |

## Verification
Every result, its gated flag and the updated gated_count come out together two rising edges after the edge that captures the operands. The bench drives inputs on falling edges and places the expected triple in a queue at the moment it drives. The monitor also works on falling edges and pops one entry for each cycle in which out_valid is high, so the comparison happens half a cycle after the outputs settle. In idle cycles the monitor instead compares result and gated against the last values it saw.

// File: rtl/gss_pkg.sv
package gss_pkg;

  // How many of the two high operand bytes are all ones, when both are trivial
  typedef enum logic [1:0] {
    SC_NONE = 2'd0,
    SC_ONE  = 2'd1,
    SC_BOTH = 2'd2
  } sign_case_e;

endpackage

// File: rtl/gss_detect.sv
module gss_detect
  import gss_pkg::*;
#(
  parameter int HW = 8
) (
  input  logic [HW-1:0] a_hi,
  input  logic [HW-1:0] b_hi,
  output logic          close,
  output sign_case_e    scase
);
  logic a_zero, a_ones, b_zero, b_ones;

  always_comb begin
    a_zero = ~|a_hi;
    a_ones = &a_hi;
    b_zero = ~|b_hi;
    b_ones = &b_hi;
    // close=0 means the high adder is not needed
    close  = ~((a_zero | a_ones) & (b_zero | b_ones));
    if (a_ones && b_ones)      scase = SC_BOTH;
    else if (a_ones || b_ones) scase = SC_ONE;
    else                       scase = SC_NONE;
  end
endmodule

// File: rtl/gss_operand_gate.sv
module gss_operand_gate #(
  parameter int HW = 8
) (
  input  logic          close,
  input  logic [HW-1:0] a_hi,
  input  logic [HW-1:0] b_hi,
  output logic [HW-1:0] a_g,
  output logic [HW-1:0] b_g
);
  // One AND gate per operand bit acts as the hold/zero element
  for (genvar i = 0; i < HW; i++) begin : g_and
    assign a_g[i] = a_hi[i] & close;
    assign b_g[i] = b_hi[i] & close;
  end
endmodule

// File: rtl/gss_low_adder.sv
module gss_low_adder #(
  parameter int LW = 8
) (
  input  logic [LW-1:0] a,
  input  logic [LW-1:0] b,
  input  logic          cin,
  output logic [LW-1:0] sum,
  output logic          cout
);
  logic [LW:0] total;

  always_comb begin
    total = {1'b0, a} + {1'b0, b} + {{LW{1'b0}}, cin};
    sum   = total[LW-1:0];
    cout  = total[LW];
  end
endmodule

// File: rtl/gss_high_rebuild.sv
module gss_high_rebuild
  import gss_pkg::*;
#(
  parameter int HW = 8
) (
  input  logic [HW-1:0] a_g,
  input  logic [HW-1:0] b_g,
  input  logic          c_in,
  input  logic          close,
  input  sign_case_e    scase,
  output logic [HW-1:0] hi_sum
);
  localparam logic [HW-1:0] ALL1 = {HW{1'b1}};
  localparam logic [HW-1:0] ONE  = {{(HW-1){1'b0}}, 1'b1};
  localparam logic [HW-1:0] FE   = {{(HW-1){1'b1}}, 1'b0};

  logic [HW-1:0] full_sum;
  logic [HW-1:0] rebuilt;

  always_comb begin
    // Real adder: inputs are zero when close=0, so it stays quiet
    full_sum = a_g + b_g + {{(HW-1){1'b0}}, c_in & close};
    // Sign-extension glue: sum of two sign bytes plus incoming carry
    unique case (scase)
      SC_BOTH: rebuilt = c_in ? ALL1 : FE;
      SC_ONE:  rebuilt = c_in ? '0 : ALL1;
      default: rebuilt = c_in ? ONE : '0;
    endcase
    hi_sum = close ? full_sum : rebuilt;
  end
endmodule

// File: rtl/glitch_split_addsub.sv
module glitch_split_addsub
  import gss_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int LOW_W  = 8,
  parameter int IN_REG = 1,
  parameter int CNT_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             sub,
  output logic             out_valid,
  output logic [WIDTH-1:0] result,
  output logic             gated,
  output logic [CNT_W-1:0] gated_count
);
  localparam int HIGH_W = WIDTH - LOW_W;
  localparam int LAT    = IN_REG + 1;

  logic             s_valid;
  logic [WIDTH-1:0] s_a;
  logic [WIDTH-1:0] s_b;
  logic             s_sub;

  // Optional operand register
  if (IN_REG != 0) begin : g_inreg
    always_ff @(posedge clk) begin
      if (rst) begin
        s_valid <= 1'b0;
        s_a     <= '0;
        s_b     <= '0;
        s_sub   <= 1'b0;
      end else begin
        s_valid <= in_valid;
        s_a     <= op_a;
        s_b     <= op_b;
        s_sub   <= sub;
      end
    end
  end else begin : g_noreg
    always_comb begin
      s_valid = in_valid;
      s_a     = op_a;
      s_b     = op_b;
      s_sub   = sub;
    end
  end

  logic [WIDTH-1:0]  b_eff;
  logic [HIGH_W-1:0] hi_a_raw, hi_b_raw, hi_a_g, hi_b_g, hi_sum;
  logic [LOW_W-1:0]  lo_sum;
  logic              lo_cout;
  logic              close_w;
  sign_case_e        scase;

  always_comb begin
    b_eff    = s_sub ? ~s_b : s_b;
    hi_a_raw = s_a[WIDTH-1:LOW_W];
    hi_b_raw = b_eff[WIDTH-1:LOW_W];
  end

  gss_low_adder #(.LW(LOW_W)) u_lo (
    .a   (s_a[LOW_W-1:0]),
    .b   (b_eff[LOW_W-1:0]),
    .cin (s_sub),
    .sum (lo_sum),
    .cout(lo_cout)
  );

  gss_detect #(.HW(HIGH_W)) u_det (
    .a_hi (hi_a_raw),
    .b_hi (hi_b_raw),
    .close(close_w),
    .scase(scase)
  );

  gss_operand_gate #(.HW(HIGH_W)) u_gate (
    .close(close_w),
    .a_hi (hi_a_raw),
    .b_hi (hi_b_raw),
    .a_g  (hi_a_g),
    .b_g  (hi_b_g)
  );

  gss_high_rebuild #(.HW(HIGH_W)) u_hi (
    .a_g   (hi_a_g),
    .b_g   (hi_b_g),
    .c_in  (lo_cout),
    .close (close_w),
    .scase (scase),
    .hi_sum(hi_sum)
  );

  // Registered outputs; result and flag hold while idle
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      result      <= '0;
      gated       <= 1'b0;
      gated_count <= '0;
    end else begin
      out_valid <= s_valid;
      if (s_valid) begin
        result <= {hi_sum, lo_sum};
        gated  <= ~close_w;
        if (!close_w) gated_count <= gated_count + 1'b1;
      end
    end
  end
endmodule

// File: rtl/gss_checker.sv
module gss_checker #(
  parameter int WIDTH = 16,
  parameter int LOW_W = 8,
  parameter int LAT   = 2,
  parameter int CNT_W = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   in_valid,
  input logic [WIDTH-1:0]       op_a,
  input logic [WIDTH-1:0]       op_b,
  input logic                   sub,
  input logic                   out_valid,
  input logic [WIDTH-1:0]       result,
  input logic                   gated,
  input logic [CNT_W-1:0]       gated_count,
  input logic                   close_w,
  input logic [WIDTH-LOW_W-1:0] hi_a_raw,
  input logic [WIDTH-LOW_W-1:0] hi_b_raw,
  input logic [WIDTH-LOW_W-1:0] hi_a_g,
  input logic [WIDTH-LOW_W-1:0] hi_b_g
);
  localparam int HW = WIDTH - LOW_W;

  logic [WIDTH-1:0] ref_now;
  logic [HW-1:0]    bh;
  logic             triv_now;

  always_comb begin
    ref_now  = sub ? (op_a - op_b) : (op_a + op_b);
    bh       = sub ? ~op_b[WIDTH-1:LOW_W] : op_b[WIDTH-1:LOW_W];
    triv_now = ((op_a[WIDTH-1:LOW_W] == '0) || (op_a[WIDTH-1:LOW_W] == {HW{1'b1}}))
            && ((bh == '0) || (bh == {HW{1'b1}}));
  end

  // R1
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0 && !gated && gated_count == '0));

  // R2
  p_gate_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !close_w |-> (hi_a_g == '0 && hi_b_g == '0));
  p_gate_pass_r2: assert property (@(posedge clk) disable iff (rst)
    close_w |-> (hi_a_g == hi_a_raw && hi_b_g == hi_b_raw));

  // R3
  p_exact_sum_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> result == $past(ref_now, LAT));

  // R4
  p_gated_flag_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> gated == $past(triv_now, LAT));

  // R5
  p_latency_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, LAT));

  // R6
  p_count_inc_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && gated) |-> gated_count == $past(gated_count) + 1'b1);
  p_count_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && gated) |-> $stable(gated_count));

  // R7
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(result) && $stable(gated)));
endmodule

bind glitch_split_addsub gss_checker #(
  .WIDTH(WIDTH), .LOW_W(LOW_W), .LAT(LAT), .CNT_W(CNT_W)
) u_gss_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .op_a       (op_a),
  .op_b       (op_b),
  .sub        (sub),
  .out_valid  (out_valid),
  .result     (result),
  .gated      (gated),
  .gated_count(gated_count),
  .close_w    (close_w),
  .hi_a_raw   (hi_a_raw),
  .hi_b_raw   (hi_b_raw),
  .hi_a_g     (hi_a_g),
  .hi_b_g     (hi_b_g)
);

// File: tb/glitch_split_addsub_bench.sv
`timescale 1ns/1ps
module glitch_split_addsub_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] op_a = '0;
  logic [15:0] op_b = '0;
  logic        sub = 1'b0;
  logic        out_valid;
  logic [15:0] result;
  logic        gated;
  logic [15:0] gated_count;

  always #2.5 clk = ~clk;

  glitch_split_addsub u_glitch_split_addsub (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .sub(sub), .out_valid(out_valid), .result(result), .gated(gated),
    .gated_count(gated_count)
  );

  typedef struct packed {
    logic [15:0] res;
    logic        g;
    logic [15:0] cnt;
  } exp_t;

  exp_t        q[$];
  int          n_checks = 0;
  int          n_fail = 0;
  logic [15:0] exp_cnt = '0;
  logic [15:0] last_res = '0;
  logic        last_g = 1'b0;
  bit          mon_on = 1'b0;
  bit          done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                     input logic [15:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, expv, $time);
    end
  endtask

  function automatic bit triv8(input logic [7:0] v);
    return (v == 8'h00) || (v == 8'hFF);
  endfunction

  // Driver: R3 arithmetic, R4 gating rule, R6 counter computed here
  task automatic op(input logic [15:0] a, input logic [15:0] b, input logic s);
    exp_t e;
    logic [7:0] bh;
    @(negedge clk);
    in_valid = 1'b1; op_a = a; op_b = b; sub = s;
    bh = s ? ~b[15:8] : b[15:8];
    e.res = s ? (a - b) : (a + b);
    e.g   = triv8(a[15:8]) && triv8(bh);
    if (e.g) exp_cnt = exp_cnt + 16'd1;
    e.cnt = exp_cnt;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      op_a = 16'hDEAD; op_b = 16'hBEEF; sub = 1'b1;
    end
  endtask

  // Monitor: results due two edges after capture (R5); idle hold (R7)
  always @(negedge clk) begin
    if (mon_on) begin
      if (out_valid) begin
        if (q.size() == 0) begin
          chk(1'b0, "R5 out_valid without request", {15'd0, out_valid}, 16'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(result == e.res, "R3/R8 result", result, e.res);
          chk(gated == e.g, "R4 gated flag", {15'd0, gated}, {15'd0, e.g});
          chk(gated_count == e.cnt, "R6 gated_count", gated_count, e.cnt);
        end
        last_res = result;
        last_g = gated;
      end else begin
        chk(result == last_res && gated == last_g, "R7 idle hold", result, last_res);
      end
    end
  end

  // Watchdog
  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] picks [4];
    picks[0] = 8'h00; picks[1] = 8'hFF; picks[2] = 8'h01; picks[3] = 8'h80;
    repeat (3) @(negedge clk);
    chk(!out_valid && result == 0 && !gated && gated_count == 0,
        "R1 reset state", result, 16'd0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!out_valid && result == 0 && !gated && gated_count == 0,
        "R1 after reset", gated_count, 16'd0);
    mon_on = 1'b1;

    // R8 boundary carries in gated mode
    op(16'h00FF, 16'h0001, 1'b0);
    op(16'hFFFF, 16'hFFFF, 1'b0);
    op(16'h0000, 16'h0001, 1'b1);
    op(16'hFF80, 16'h0080, 1'b0);
    op(16'h0000, 16'h0000, 1'b0);
    op(16'hFF00, 16'h00FF, 1'b1);
    idle(3);
    // R2/R4 non-gated: high bytes need real adder
    op(16'h1234, 16'h0101, 1'b0);
    op(16'h7FFF, 16'h0001, 1'b0);
    op(16'h8000, 16'h0001, 1'b1);
    op(16'h00FF, 16'h0100, 1'b1);
    idle(2);

    // R2/R4 biased patterns around trivial bytes
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a, b;
      a = {picks[$urandom_range(0, 3)], 8'($urandom)};
      b = {picks[$urandom_range(0, 3)], 8'($urandom)};
      op(a, b, 1'($urandom));
      if (($urandom % 8) == 0) idle(1);
    end
    // R3 random
    for (int i = 0; i < 1500; i++) begin
      op(16'($urandom), 16'($urandom), 1'($urandom));
      if (($urandom % 16) == 0) idle($urandom_range(1, 3));
    end
    idle(6);
    chk(q.size() == 0, "R5 all results delivered", 16'(q.size()), 16'd0);
    chk(gated_count == exp_cnt, "R6 final count", gated_count, exp_cnt);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule